// File: doc/BRIEF.md
# E1 Data Link Bit Extractor

This block sits behind an E1 receive framer and pulls the bits that carry a data link out of the 2.048 Mbit/s stream. It passes them on as a serial bit with a one-cycle valid strobe, ready for an HDLC receiver. The framer supplies the received bit, a bit clock enable, the time-slot number, the bit position inside the slot and the least significant bit of its frame counter. Flag detection, bit de-stuffing and CRC are left to the downstream receiver.

Three link settings are held side by side. Each setting can enable odd frames, even frames or both. It names one time slot (0 to 31) and carries an 8-bit mask that picks bits inside that slot. Each setting also has an override that takes all of time slot 16 in every frame. A 2-bit selector chooses which setting drives the output, and a global off control silences the output entirely. All of these controls are captured at the first bit of each frame, so a frame is never extracted with a mix of old and new settings.

Top module: `e1_dlink_extract`

## Requirements
- R1: After reset the output valid is 0. No bit is extracted until the first frame start, which is a strobed bit with time slot 0 and bit position 0.
- R2: With the override off, a bit is taken only in frames whose parity is enabled. `frame_lsb` = 0 is an even frame and 1 is an odd frame, and setting both enables takes bits in every frame.
- R3: With the override off, only the time slot equal to the link's 5-bit slot field is used, and any value from 0 to 31 works.
- R4: Mask bit 7-p selects the bit at position p, where position 0 is the first bit received in the slot. Mask 8'h01 therefore takes only the last bit, and 8'hFF takes the whole slot.
- R5: When a link's override bit is 1, all eight bits of slot 16 are taken in every frame. The parity enables, slot field and mask have no effect.
- R6: Selector value 0 drives the output from link 1, 1 from link 2 and 2 from link 3. Value 3 drives no link, so valid stays 0.
- R7: While the captured global off control is 1, the output valid stays 0.
- R8: An extracted bit appears on `dl_bit` one clock after the strobed input cycle, with `dl_valid` high for that single cycle. `dl_bit` equals the `rx_bit` of that input cycle.
- R9: Configuration, selector and off control are sampled at a frame start. That sample governs the whole frame, starting with its first bit, and changes made mid-frame act only from the next frame start.
- R10: Cycles with `bit_en` = 0 produce no output, whatever the data and position inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Strobe: one received bit is present this cycle |
| rx_bit | input | 1 | Received data bit |
| frame_lsb | input | 1 | LSB of the framer's frame count (1 = odd frame) |
| ts_num | input | 5 | Time slot of the current bit |
| bit_pos | input | 3 | Bit position inside the slot, 0 = first received |
| link_sel | input | 2 | Link setting that drives the output (3 = none) |
| path_off | input | 1 | Global off control, 1 silences the output |
| cfg_even | input | 3 | Even-frame enable, one bit per link |
| cfg_odd | input | 3 | Odd-frame enable, one bit per link |
| cfg_ovr | input | 3 | Slot-16 override, one bit per link |
| cfg_slot | input | 15 | Slot number, 5 bits per link, link 1 in bits 4:0 |
| cfg_mask | input | 24 | Bit mask, 8 bits per link, link 1 in bits 7:0 |
| dl_bit | output | 1 | Extracted data link bit |
| dl_valid | output | 1 | One-cycle strobe for `dl_bit` |

## Verification
Two things can fall in the same cycle: the capture of new settings at a frame start and the extraction of that frame's very first bit. The bench changes the settings in the middle of a frame, to a slot-0 mask that takes only position 0. The old settings must then stay in force for the rest of that frame. The next frame's first bit must be taken under the new settings in the same cycle that they are captured. The bench judges this from the total number of extracted bits, which differs if the new settings act immediately or one bit late. A per-bit model checks each bit's value and timing.

// File: rtl/dlx_pkg.sv
package dlx_pkg;
  localparam int unsigned TS_W      = 5;
  localparam int unsigned POS_W     = 3;
  localparam int unsigned SLOT_BITS = 1 << POS_W;

  typedef struct packed {
    logic                 even_en;
    logic                 odd_en;
    logic                 ovr_en;
    logic [TS_W-1:0]      slot;
    logic [SLOT_BITS-1:0] mask;
  } link_cfg_t;
endpackage

// File: rtl/dlx_frame_pos.sv
module dlx_frame_pos
  import dlx_pkg::*;
#(
  parameter int unsigned OVR_SLOT = 16
) (
  input  logic                 bit_en,
  input  logic                 frame_lsb,
  input  logic [TS_W-1:0]      ts_num,
  input  logic [POS_W-1:0]     bit_pos,
  output logic                 frame_start,
  output logic                 odd_frame,
  output logic [SLOT_BITS-1:0] pos_sel,
  output logic                 ovr_slot
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOT_BITS - 1);

  always_comb begin
    frame_start = bit_en && (ts_num == '0) && (bit_pos == '0);
    odd_frame   = frame_lsb;
    ovr_slot    = (ts_num == TS_W'(OVR_SLOT));
    pos_sel     = '0;
    pos_sel[LAST_POS - bit_pos] = 1'b1;
  end
endmodule

// File: rtl/dlx_link_match.sv
module dlx_link_match
  import dlx_pkg::*;
#(
  parameter int unsigned OVR_SLOT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 bit_en,
  input  logic                 odd_frame,
  input  logic                 ovr_slot,
  input  logic [TS_W-1:0]      ts_num,
  input  logic [SLOT_BITS-1:0] pos_sel,
  input  link_cfg_t            live_cfg,
  output logic                 hit
);
  link_cfg_t shadow_q;
  link_cfg_t shadow_d;
  logic      par_ok;
  logic      slot_ok;
  logic      bit_ok;

  always_comb begin
    shadow_d = frame_start ? live_cfg : shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (frame_start) begin
      shadow_q <= shadow_d;
    end
  end

  always_comb begin
    par_ok  = odd_frame ? shadow_d.odd_en : shadow_d.even_en;
    slot_ok = (ts_num == shadow_d.slot);
    bit_ok  = |(shadow_d.mask & pos_sel);
    if (shadow_d.ovr_en) begin
      hit = bit_en && ovr_slot;
    end else begin
      hit = bit_en && par_ok && slot_ok && bit_ok;
    end
  end

  AST_OVR_SLOT16: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && shadow_d.ovr_en) |-> (ts_num == TS_W'(OVR_SLOT))); // R5

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(shadow_q)); // R9
endmodule

// File: rtl/dlx_out_stage.sv
module dlx_out_stage #(
  parameter int unsigned N_LINKS = 3,
  parameter int unsigned SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               bit_en,
  input  logic               rx_bit,
  input  logic [SEL_W-1:0]   live_sel,
  input  logic               live_off,
  input  logic [N_LINKS-1:0] link_hit,
  output logic               dl_bit,
  output logic               dl_valid
);
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_d;
  logic             off_q;
  logic             off_d;
  logic             pick;
  logic             valid_d;
  logic             bit_d;

  always_comb begin
    sel_d = frame_start ? live_sel : sel_q;
    off_d = frame_start ? live_off : off_q;
    pick  = 1'b0;
    for (int i = 0; i < int'(N_LINKS); i++) begin
      if (sel_d == SEL_W'(i)) begin
        pick = link_hit[i];
      end
    end
    valid_d = bit_en && !off_d && pick;
    bit_d   = valid_d && rx_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      off_q <= 1'b1;
    end else if (frame_start) begin
      sel_q <= sel_d;
      off_q <= off_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_valid <= 1'b0;
      dl_bit   <= 1'b0;
    end else begin
      dl_valid <= valid_d;
      dl_bit   <= bit_d;
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q && !frame_start) |=> !dl_valid); // R7

  AST_SEL_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(sel_q) >= N_LINKS) && !frame_start) |=> !dl_valid); // R6

  AST_VALID_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dl_valid |-> $past(bit_en)); // R10

  AST_BIT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dl_valid |-> (dl_bit == $past(rx_bit))); // R8
endmodule

// File: rtl/e1_dlink_extract.sv
module e1_dlink_extract
  import dlx_pkg::*;
#(
  parameter int unsigned N_LINKS  = 3,
  parameter int unsigned OVR_SLOT = 16,
  parameter int unsigned SEL_W    = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bit_en,
  input  logic                           rx_bit,
  input  logic                           frame_lsb,
  input  logic [TS_W-1:0]                ts_num,
  input  logic [POS_W-1:0]               bit_pos,
  input  logic [SEL_W-1:0]               link_sel,
  input  logic                           path_off,
  input  logic [N_LINKS-1:0]             cfg_even,
  input  logic [N_LINKS-1:0]             cfg_odd,
  input  logic [N_LINKS-1:0]             cfg_ovr,
  input  logic [N_LINKS*TS_W-1:0]        cfg_slot,
  input  logic [N_LINKS*SLOT_BITS-1:0]   cfg_mask,
  output logic                           dl_bit,
  output logic                           dl_valid
);
  logic                 frame_start;
  logic                 odd_frame;
  logic                 ovr_slot;
  logic [SLOT_BITS-1:0] pos_sel;
  logic [N_LINKS-1:0]   link_hit;

  dlx_frame_pos #(.OVR_SLOT(OVR_SLOT)) u_pos (
    .bit_en      (bit_en),
    .frame_lsb   (frame_lsb),
    .ts_num      (ts_num),
    .bit_pos     (bit_pos),
    .frame_start (frame_start),
    .odd_frame   (odd_frame),
    .pos_sel     (pos_sel),
    .ovr_slot    (ovr_slot)
  );

  for (genvar g = 0; g < int'(N_LINKS); g++) begin : g_link
    link_cfg_t live_c;
    assign live_c = '{
      even_en: cfg_even[g],
      odd_en:  cfg_odd[g],
      ovr_en:  cfg_ovr[g],
      slot:    cfg_slot[g*TS_W +: TS_W],
      mask:    cfg_mask[g*SLOT_BITS +: SLOT_BITS]
    };

    dlx_link_match #(.OVR_SLOT(OVR_SLOT)) u_match (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .bit_en      (bit_en),
      .odd_frame   (odd_frame),
      .ovr_slot    (ovr_slot),
      .ts_num      (ts_num),
      .pos_sel     (pos_sel),
      .live_cfg    (live_c),
      .hit         (link_hit[g])
    );
  end

  dlx_out_stage #(.N_LINKS(N_LINKS), .SEL_W(SEL_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .bit_en      (bit_en),
    .rx_bit      (rx_bit),
    .live_sel    (link_sel),
    .live_off    (path_off),
    .link_hit    (link_hit),
    .dl_bit      (dl_bit),
    .dl_valid    (dl_valid)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_n)) |-> !dl_valid); // R1
endmodule

// File: tb/e1_dlink_extract_bench.sv
module e1_dlink_extract_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_en, rx_bit, frame_lsb, path_off;
  logic [4:0]  ts_num;
  logic [2:0]  bit_pos;
  logic [1:0]  link_sel;
  logic [2:0]  cfg_even, cfg_odd, cfg_ovr;
  logic [14:0] cfg_slot;
  logic [23:0] cfg_mask;
  logic        dl_bit, dl_valid;

  logic [1:0]  act_sel;
  logic        act_off;
  logic [2:0]  act_even, act_odd, act_ovr;
  logic [14:0] act_slot;
  logic [23:0] act_mask;

  logic        pend_v, pend_d;
  logic [15:0] lfsr;
  int          n_checks, n_fails, mism, got;
  bit          done;

  always #5 clk = ~clk;

  e1_dlink_extract u_e1_dlink_extract (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .frame_lsb(frame_lsb), .ts_num(ts_num), .bit_pos(bit_pos),
    .link_sel(link_sel), .path_off(path_off), .cfg_even(cfg_even),
    .cfg_odd(cfg_odd), .cfg_ovr(cfg_ovr), .cfg_slot(cfg_slot),
    .cfg_mask(cfg_mask), .dl_bit(dl_bit), .dl_valid(dl_valid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic model_hit(input int ts, input int b, input logic odd);
    int   s;
    logic par;
    if (act_off || act_sel == 2'd3) return 1'b0;
    s = int'(act_sel);
    if (act_ovr[s]) return (ts == 16);
    par = odd ? act_odd[s] : act_even[s];
    return par && (ts == int'(act_slot[s*5 +: 5])) && act_mask[s*8 + (7 - b)];
  endfunction

  task automatic step(input logic en, input int ts, input int b, input logic odd);
    logic d;
    @(negedge clk);
    if (dl_valid !== pend_v || (pend_v && dl_bit !== pend_d)) begin
      mism++;
      if (mism <= 3)
        $display("mismatch ts=%0d b=%0d: valid %b/%b bit %b/%b", ts, b, dl_valid, pend_v, dl_bit, pend_d);
    end
    if (dl_valid === 1'b1) got++;
    d    = lfsr[0];
    lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    bit_en    = en;
    rx_bit    = d;
    ts_num    = 5'(ts);
    bit_pos   = 3'(b);
    frame_lsb = odd;
    if (en && ts == 0 && b == 0) begin
      act_sel = link_sel;  act_off = path_off;
      act_even = cfg_even; act_odd = cfg_odd; act_ovr = cfg_ovr;
      act_slot = cfg_slot; act_mask = cfg_mask;
    end
    pend_v = en && model_hit(ts, b, odd);
    pend_d = d;
  endtask

  task automatic run_part(input int frm, input int ts_lo, input int ts_hi, input bit gap);
    for (int ts = ts_lo; ts <= ts_hi; ts++)
      for (int b = 0; b < 8; b++) begin
        step(1'b1, ts, b, frm[0]);
        if (gap) step(1'b0, ts, b, ~frm[0]);
      end
  endtask

  task automatic scn_begin();
    mism = 0;
    got  = 0;
  endtask

  task automatic scn_end(input string tag, input int exp);
    step(1'b0, 1, 1, 1'b0);
    check(mism == 0, {tag, " per-bit mismatches"}, mism, 0);
    check(got == exp, {tag, " extracted count"}, got, exp);
  endtask

  task automatic set_link(input int l, input logic ev, input logic od, input logic ov,
                          input int slot, input logic [7:0] mask);
    cfg_even[l] = ev; cfg_odd[l] = od; cfg_ovr[l] = ov;
    cfg_slot[l*5 +: 5] = 5'(slot);
    cfg_mask[l*8 +: 8] = mask;
  endtask

  task automatic clear_links();
    cfg_even = '0; cfg_odd = '0; cfg_ovr = '0; cfg_slot = '0; cfg_mask = '0;
  endtask

  // R1: nothing before the first frame start
  task automatic t_reset();
    @(negedge clk);
    check(dl_valid == 1'b0, "R1 valid after reset", int'(dl_valid), 0);
    scn_begin();
    set_link(0, 1, 1, 0, 5, 8'hFF);
    link_sel = 2'd0; path_off = 1'b0;
    run_part(0, 3, 31, 0);
    scn_end("R1 no output before frame start", 0);
  endtask

  // R2 R3 R4 R8: even frames only, whole slot 3
  task automatic t_even();
    scn_begin();
    clear_links(); set_link(0, 1, 0, 0, 3, 8'hFF); link_sel = 2'd0;
    run_part(0, 0, 31, 0); run_part(1, 0, 31, 0);
    scn_end("R2 R3 R8 even-only slot 3", 8);
  endtask

  // R2 R4: odd frames only, last bit of slot 0
  task automatic t_sa8();
    scn_begin();
    clear_links(); set_link(0, 0, 1, 0, 0, 8'h01);
    for (int f = 0; f < 4; f++) run_part(f, 0, 31, 0);
    scn_end("R4 R2 odd-only last bit slot 0", 2);
  endtask

  // R5 R6: link 2 override, link 1 would hit elsewhere
  task automatic t_ovr();
    scn_begin();
    clear_links();
    set_link(0, 1, 1, 0, 3, 8'hFF);
    set_link(1, 0, 0, 1, 5, 8'h3C);
    link_sel = 2'd1;
    run_part(0, 0, 31, 0); run_part(1, 0, 31, 0);
    scn_end("R5 R6 slot-16 override on link 2", 16);
  endtask

  // R3 R4 R6: link 3 slot 31 mask 81, then selector 3
  task automatic t_link3();
    scn_begin();
    clear_links();
    set_link(0, 1, 1, 0, 31, 8'hFF);
    set_link(2, 1, 1, 0, 31, 8'h81);
    link_sel = 2'd2;
    run_part(2, 0, 31, 0); run_part(3, 0, 31, 0);
    scn_end("R3 R4 R6 link 3 slot 31", 4);
    scn_begin();
    link_sel = 2'd3;
    run_part(4, 0, 31, 0);
    scn_end("R6 selector 3 drives nothing", 0);
  endtask

  // R7: global off
  task automatic t_off();
    scn_begin();
    clear_links(); set_link(0, 1, 1, 0, 9, 8'hFF); link_sel = 2'd0; path_off = 1'b1;
    run_part(0, 0, 31, 0);
    scn_end("R7 global off silences output", 0);
    path_off = 1'b0;
  endtask

  // R10: idle cycles between strobes
  task automatic t_gap();
    scn_begin();
    clear_links(); set_link(0, 1, 1, 0, 7, 8'hF0); link_sel = 2'd0;
    run_part(0, 0, 31, 1); run_part(1, 0, 31, 1);
    scn_end("R10 no output without strobe", 8);
  endtask

  // R9: mid-frame change acts from next frame start, including its first bit
  task automatic t_midframe();
    scn_begin();
    clear_links(); set_link(0, 1, 1, 0, 20, 8'hFF); link_sel = 2'd0;
    run_part(0, 0, 9, 0);
    set_link(0, 1, 1, 0, 0, 8'h80);
    run_part(0, 10, 31, 0);
    run_part(1, 0, 31, 0);
    scn_end("R9 frame-boundary capture", 9);
  endtask

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b0; frame_lsb = 1'b0; path_off = 1'b1;
    ts_num = '0; bit_pos = '0; link_sel = '0;
    clear_links();
    act_sel = '0; act_off = 1'b1;
    act_even = '0; act_odd = '0; act_ovr = '0; act_slot = '0; act_mask = '0;
    pend_v = 1'b0; pend_d = 1'b0; lfsr = 16'hACE1;
    n_checks = 0; n_fails = 0; done = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_even();
    t_sa8();
    t_ovr();
    t_link3();
    t_off();
    t_gap();
    t_midframe();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule